// File: doc/BRIEF.md
# Serial Divide-by-Three Engine

This block divides a binary number by three while the number streams in one bit per clock, most significant bit first. It keeps only the remainder of the bits seen so far. Each accepted bit moves the remainder to (2 x remainder + bit) mod 3. In the same cycle the block gives one quotient bit, so the quotient leaves the block at the same rate as the dividend arrives. When the last bit has been accepted, the remainder output holds the dividend mod 3, and the quotient bits, collected in arrival order, form the dividend divided by three.

A producer raises `start` with the first bit of a new number, or on its own to clear the state. It raises `bit_valid` on every cycle that carries a dividend bit. Cycles with `bit_valid` low are idle cycles, so the producer can leave gaps inside a number. The parameter `QUOT_REG` chooses how the quotient bit is produced. With 0 (the default) the quotient bit is a Mealy output, formed combinationally in the same cycle as its input bit. With 1 it is registered and appears one cycle later. The remainder is always a Moore output: it is the state register itself.

Top module: `serial_div3`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `remainder` reads 00.
- R2: The remainder encodes as 00 for 0, 01 for 1 and 10 for 2. After every accepted bit, `remainder` equals the value of the bits accepted since the last start, read most significant bit first, mod 3. The new value is visible one clock edge after the bit.
- R3: With `QUOT_REG`=0, during a cycle with `bit_valid` high, `quot_bit` is 1 exactly when 2 x r + `bit_in` is 3 or more. Here r is the current remainder, or 0 if `start` is high in that cycle. In every cycle with `bit_valid` low, `quot_bit` is 0.
- R4: In a cycle where both `bit_valid` and `start` are low, `bit_in` is ignored and `remainder` keeps its value.
- R5: `start` high with `bit_valid` low sets `remainder` to 00 at the next edge. `start` high with `bit_valid` high makes `bit_in` the first bit of a new number, so the next remainder is `bit_in` mod 3.
- R6: `remainder` never reads 11. If the state register ever holds 11, it returns to 00 at the next edge.
- R7: For an N-bit number sent as N accepted bits after a start, the final `remainder` equals the number mod 3, and the N quotient bits, the first received being the most significant, equal the number divided by 3 (integer division).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous clear; marks the first bit of a new number when `bit_valid` is also high |
| bit_valid | input | 1 | High on cycles that carry a dividend bit |
| bit_in | input | 1 | Dividend bit, most significant first |
| remainder | output | 2 | Remainder so far (00, 01, 10) |
| quot_bit | output | 1 | Quotient bit for the current input bit |

## Verification
The assertions assume that `start`, `bit_valid` and `bit_in` are never X or Z after reset, and that they change only away from the rising edge. The bench meets this by driving every input on the falling edge, from known values onward. The assertions also assume that nothing writes the state register except the block itself, which is why the 11 encoding can appear only through a fault. The random stimulus uses 16-bit dividends from a fixed seed. It puts idle gaps inside numbers, and it restarts numbers both with and without a bit in the start cycle. Each of these input patterns has its own assertion.

// File: rtl/div3_pkg.sv
package div3_pkg;

  localparam int unsigned REM_W = 2;
  localparam int unsigned DIVISOR = 3;

  typedef enum logic [REM_W-1:0] {
    REM_ZERO = 2'b00,
    REM_ONE  = 2'b01,
    REM_TWO  = 2'b10,
    REM_BAD  = 2'b11
  } rem_t;

  // Shifted partial dividend: 2*r + b, range 0..5 for legal r
  function automatic logic [REM_W:0] partial_of(input rem_t r, input logic b);
    return {r, b};
  endfunction

  // Quotient digit produced by one step
  function automatic logic quot_of(input rem_t r, input logic b);
    if (r == REM_BAD) return 1'b0;
    return (partial_of(r, b) >= (REM_W+1)'(DIVISOR));
  endfunction

  // Remainder after one step; the unused code falls back to zero
  function automatic rem_t next_of(input rem_t r, input logic b);
    rem_t res;
    case (partial_of(r, b))
      3'd0, 3'd3: res = REM_ZERO;
      3'd1, 3'd4: res = REM_ONE;
      3'd2, 3'd5: res = REM_TWO;
      default:    res = REM_ZERO;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/div3_step.sv
module div3_step
  import div3_pkg::*;
(
  input  rem_t cur_rem,
  input  logic bit_in,
  output rem_t nxt_rem,
  output logic qbit,
  output logic illegal
);

  always_comb begin
    illegal = (cur_rem == REM_BAD);
    nxt_rem = next_of(cur_rem, bit_in);
    qbit    = quot_of(cur_rem, bit_in);
  end

endmodule

// File: rtl/div3_state.sv
module div3_state
  import div3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rem_t d,
  output rem_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= REM_ZERO;
    else if (load) q <= d;
  end

endmodule

// File: rtl/serial_div3.sv
module serial_div3
  import div3_pkg::*;
#(
  parameter bit QUOT_REG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic [1:0] remainder,
  output logic       quot_bit
);

  rem_t state_q;
  rem_t eff_rem;
  rem_t step_rem;
  rem_t load_val;
  logic step_q;
  logic state_bad;
  logic take_bit;
  logic hold_ev;
  logic clear_ev;
  logic q_raw;

  // Named events for the checks below
  assign take_bit = bit_valid;
  assign clear_ev = start & ~bit_valid;
  assign hold_ev  = ~start & ~bit_valid;

  assign eff_rem = start ? REM_ZERO : state_q;

  div3_step u_step (
    .cur_rem (eff_rem),
    .bit_in  (bit_in),
    .nxt_rem (step_rem),
    .qbit    (step_q),
    .illegal (state_bad)
  );

  // A stuck illegal code is also cleared on idle cycles
  always_comb begin
    if (take_bit) load_val = step_rem;
    else          load_val = REM_ZERO;
  end

  div3_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take_bit | start | state_bad),
    .d     (load_val),
    .q     (state_q)
  );

  assign q_raw     = take_bit & step_q;
  assign remainder = state_q;

  generate
    if (QUOT_REG) begin : g_moore_q
      logic q_reg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_reg <= 1'b0;
        else        q_reg <= q_raw;
      end
      assign quot_bit = q_reg;
    end else begin : g_mealy_q
      assign quot_bit = q_raw;

      // R3: no quotient digit on idle cycles
      p_qbit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !quot_bit);

      // R3: a step from remainder zero can never yield a digit of one
      p_qbit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (start || remainder == 2'b00)) |-> !quot_bit);
    end
  endgenerate

  // R4: idle cycles keep the remainder
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ev && !state_bad) |=> $stable(remainder));

  // R5: a bare start clears
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ev |=> (remainder == 2'b00));

  // R5: start with a bit restarts from that bit alone
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bit_valid) |=> (remainder == {1'b0, $past(bit_in)}));

  // R6: the unused code is never visible
  p_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remainder != 2'b11);

  // R6: recovery from the unused code
  p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_bad |=> (remainder == 2'b00));

endmodule

// File: tb/test_serial_div3.sv
module test_serial_div3;

  localparam int NBITS = 16;
  localparam int NRAND = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [1:0] remainder;
  logic       quot_bit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference prefix value and collected quotient
  longint unsigned prefix;
  longint unsigned qacc;

  always #2 clk = ~clk;

  serial_div3 i_serial_div3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .remainder (remainder),
    .quot_bit  (quot_bit)
  );

  function automatic longint unsigned ref_mod(input longint unsigned v);
    return v - (v / 3) * 3;
  endfunction

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, check Mealy output, then remainder after edge
  task automatic cycle(input logic st, input logic v, input logic b);
    logic [1:0] rem_before;
    longint unsigned base;
    @(negedge clk);
    start = st; bit_valid = v; bit_in = b;
    rem_before = remainder;
    #1;
    base = st ? 0 : prefix;
    if (v) begin
      // R3: digit is 1 when the doubled prefix plus bit crosses a multiple of three
      check("R3", quot_bit,
            ((ref_mod(base) * 2 + b) >= 3) ? 1 : 0);
      prefix = base * 2 + b;
      qacc = qacc * 2 + quot_bit;
    end else begin
      check("R3", quot_bit, 0);
      if (st) begin prefix = 0; qacc = 0; end
    end
    @(posedge clk); #1;
    check("R6", (remainder == 2'b11) ? 1 : 0, 0);
    if (v) check(st ? "R5" : "R2", remainder, ref_mod(prefix));
    else if (st) check("R5", remainder, 0);
    else check("R4", remainder, rem_before);
  endtask

  task automatic send_number(input longint unsigned val, input bit gaps);
    qacc = 0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 4 == 0)) cycle(1'b0, 1'b0, $urandom % 2);
      cycle(i == NBITS - 1, 1'b1, val[i]);
    end
    check("R7", remainder, val % 3);
    check("R7", qacc, val / 3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    prefix = 0; qacc = 0;
    #1;
    check("R1", remainder, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", remainder, 0);

    // Directed corners
    send_number(64'h0000, 1'b0);
    send_number(64'hFFFF, 1'b0);
    send_number(64'h0003, 1'b0);
    send_number(64'h8001, 1'b0);
    // R4: idle cycles with toggling data
    cycle(1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 1'b0);
    // R5: bare start mid-number, then start carrying a bit
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);

    // Random numbers with and without gaps
    for (int k = 0; k < NRAND; k++) begin
      send_number(longint'($urandom % 65536), k[0]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule